// File: doc/BRIEF.md
# Eight-Bit Arithmetic Unit with Status Word

This block is the execution stage of a small 8-bit processor core. It takes a first operand, a second operand chosen from a register value or an immediate, and a 4-bit operation code. It returns the result combinationally in the same cycle. At the next clock edge it records the outcome in an 8-bit status word. That word holds six condition flags: carry, zero, negative, overflow, sign and half-carry. It also holds a bit-transfer cell, which two operations use to move a single bit out of one register value and into another, and a global interrupt gate. The gate passes the interrupt request lines on only while it is set.

The decoder drives `op_valid` for each executed operation. Software can replace the whole status word through `sreg_we`/`sreg_wdata`, for example when restoring context after an interrupt handler. The result has no register stage. The caller writes it back into its own register file.

Status word bit positions: 7 = interrupt gate (I), 6 = transfer cell (T), 5 = half carry (H), 4 = sign (S), 3 = overflow (V), 2 = negative (N), 1 = zero (Z), 0 = carry (C).

Top module: `alu8_core`

## Requirements
- R1: After reset the status word reads 8'h00.
- R2: With `use_imm`=1 the second operand is `imm`; with `use_imm`=0 it is `reg_b`.
- R3: ADD (op 0) gives A+B and ADC (op 1) gives A+B+C. In both, C is the carry out of bit 7, H is the carry out of bit 3, and V is set when both operands have the same sign bit and the result's sign bit differs.
- R4: SUB (op 2) gives A-B and SBC (op 3) gives A-B-C. C is the borrow from bit 7, H is the borrow from bit 3, and V is set when the operands differ in sign and the result's sign differs from A. After SBC, Z is 1 only if it was already 1 and the result is zero.
- R5: AND (op 4), OR (op 5) and EOR (op 6) clear V and leave C and H unchanged. COM (op 7) returns ~A, clears V, sets C and leaves H unchanged.
- R6: NEG (op 8) returns 0-A. C is set when A is nonzero, V is set when A is 8'h80, and H is the borrow from bit 3.
- R7: INC (op 9) and DEC (op 10) return A+1 and A-1. V is set for INC of 8'h7F and DEC of 8'h80. C and H are unchanged.
- R8: LSR (op 11), ROR (op 12) and ASR (op 13) shift A right by one. The top bit is filled with 0, with the old C, or with A[7] respectively. C takes A[0], V = N XOR C, and H is unchanged.
- R9: After every operation with code 0 to 13, N equals result bit 7, S = N XOR V, and Z is set exactly when the result is zero (SBC excepted, see R4).
- R10: BST (op 14) copies A[`bit_sel`] into T and returns A. BLD (op 15) returns A with bit `bit_sel` replaced by T. Both leave every other status bit unchanged.
- R11: With `op_valid`=0 the status word keeps its value, while `result` still follows the inputs.
- R12: `sreg_we`=1 loads `sreg_wdata` into the status word at the next edge and overrides any update from an operation in the same cycle.
- R13: `irq_gated` equals `irq_req` while I is 1 and is all zeros while I is 0.
- R14: `result` is valid in the same cycle as its inputs, and the flags it produces appear in `sreg` after the following rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Operation executes this cycle; flags update at the edge |
| op_code | input | 4 | Operation code (0..15, see requirements) |
| use_imm | input | 1 | Select `imm` instead of `reg_b` as second operand |
| reg_a | input | 8 | First operand |
| reg_b | input | 8 | Second operand from the register file |
| imm | input | 8 | Immediate second operand |
| bit_sel | input | 3 | Bit index for BST and BLD |
| result | output | 8 | Combinational result |
| sreg_we | input | 1 | Direct load of the status word |
| sreg_wdata | input | 8 | Value for the direct load |
| sreg | output | 8 | Status word |
| irq_req | input | 4 | Interrupt request lines |
| irq_gated | output | 4 | Requests passed on by the interrupt gate |

## Verification
The bench sweeps every first-operand value against sixteen second-operand values for each of the fourteen flag-producing operations. The results are chained, so the incoming carry and zero alternate naturally. This exposes an SBC that recomputes Z instead of keeping it sticky, and an ADC or ROR that ignores the incoming carry. The bench also watches the boundary values 8'h7F, 8'h80 and 8'h00, where a wrong overflow rule, a NEG carry taken from the raw borrow, or an INC/DEC that disturbs C would show up. It walks every bit index for BST and BLD, checks that a same-cycle direct write wins over an operation, and checks that the gate blocks requests once I is cleared.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    typedef enum logic [3:0] {
        OP_ADD = 4'd0,
        OP_ADC = 4'd1,
        OP_SUB = 4'd2,
        OP_SBC = 4'd3,
        OP_AND = 4'd4,
        OP_OR  = 4'd5,
        OP_EOR = 4'd6,
        OP_COM = 4'd7,
        OP_NEG = 4'd8,
        OP_INC = 4'd9,
        OP_DEC = 4'd10,
        OP_LSR = 4'd11,
        OP_ROR = 4'd12,
        OP_ASR = 4'd13,
        OP_BST = 4'd14,
        OP_BLD = 4'd15
    } alu_op_e;

    // status word bit positions
    localparam int FLG_C = 0;
    localparam int FLG_Z = 1;
    localparam int FLG_N = 2;
    localparam int FLG_V = 3;
    localparam int FLG_S = 4;
    localparam int FLG_H = 5;
    localparam int FLG_T = 6;
    localparam int FLG_I = 7;
    localparam int SW_W  = 8;

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          cin,
    input  logic          sub,
    output logic [DW-1:0] sum,
    output logic          cout,
    output logic          hc,
    output logic          ovf
);
    localparam int HB  = DW / 2;
    localparam int MSB = DW - 1;

    logic [DW:0] full;
    logic [HB:0] low;

    always_comb begin
        if (sub) begin
            full = {1'b0, a} - {1'b0, b} - {{DW{1'b0}}, cin};
            low  = {1'b0, a[HB-1:0]} - {1'b0, b[HB-1:0]} - {{HB{1'b0}}, cin};
        end else begin
            full = {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, cin};
            low  = {1'b0, a[HB-1:0]} + {1'b0, b[HB-1:0]} + {{HB{1'b0}}, cin};
        end
        sum  = full[DW-1:0];
        cout = full[DW];
        hc   = low[HB];
        if (sub)
            ovf = (a[MSB] & ~b[MSB] & ~sum[MSB]) | (~a[MSB] & b[MSB] & sum[MSB]);
        else
            ovf = (a[MSB] & b[MSB] & ~sum[MSB]) | (~a[MSB] & ~b[MSB] & sum[MSB]);
    end

endmodule

// File: rtl/alu8_bitops.sv
module alu8_bitops
    import alu8_pkg::*;
#(
    parameter int DW = 8,
    localparam int SW = $clog2(DW)
) (
    input  alu_op_e       op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          cin,
    input  logic          tbit,
    input  logic [SW-1:0] bsel,
    output logic [DW-1:0] res
);
    logic [DW-1:0] ins;

    always_comb begin
        ins       = a;
        ins[bsel] = tbit;
        unique case (op)
            OP_AND:  res = a & b;
            OP_OR:   res = a | b;
            OP_EOR:  res = a ^ b;
            OP_COM:  res = ~a;
            OP_LSR:  res = {1'b0, a[DW-1:1]};
            OP_ROR:  res = {cin, a[DW-1:1]};
            OP_ASR:  res = {a[DW-1], a[DW-1:1]};
            OP_BLD:  res = ins;
            default: res = a;
        endcase
    end

endmodule

// File: rtl/alu8_status.sv
module alu8_status
    import alu8_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            upd,
    input  logic [SW_W-1:0] next_flags,
    input  logic            we,
    input  logic [SW_W-1:0] wdata,
    output logic [SW_W-1:0] word
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            word <= '0;
        else if (we)
            word <= wdata;
        else if (upd)
            word <= next_flags;
    end

endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
#(
    parameter int DW    = 8,
    parameter int IRQ_N = 4,
    localparam int SW   = $clog2(DW)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic [3:0]       op_code,
    input  logic             use_imm,
    input  logic [DW-1:0]    reg_a,
    input  logic [DW-1:0]    reg_b,
    input  logic [DW-1:0]    imm,
    input  logic [SW-1:0]    bit_sel,
    output logic [DW-1:0]    result,
    input  logic             sreg_we,
    input  logic [SW_W-1:0]  sreg_wdata,
    output logic [SW_W-1:0]  sreg,
    input  logic [IRQ_N-1:0] irq_req,
    output logic [IRQ_N-1:0] irq_gated
);
    alu_op_e       op;
    logic [DW-1:0] opnd_b;
    logic [DW-1:0] as_a, as_b, as_sum, bo_res;
    logic          as_cin, as_sub, as_cout, as_hc, as_ovf;
    logic          is_arith;
    logic [SW_W-1:0] nf;

    assign op     = alu_op_e'(op_code);
    assign opnd_b = use_imm ? imm : reg_b;

    always_comb begin
        as_a     = reg_a;
        as_b     = opnd_b;
        as_cin   = 1'b0;
        as_sub   = 1'b0;
        is_arith = 1'b1;
        unique case (op)
            OP_ADD: ;
            OP_ADC: as_cin = sreg[FLG_C];
            OP_SUB: as_sub = 1'b1;
            OP_SBC: begin as_sub = 1'b1; as_cin = sreg[FLG_C]; end
            OP_NEG: begin as_a = '0; as_b = reg_a; as_sub = 1'b1; end
            OP_INC: as_b = DW'(1);
            OP_DEC: begin as_b = DW'(1); as_sub = 1'b1; end
            default: is_arith = 1'b0;
        endcase
    end

    alu8_addsub #(.DW(DW)) u_addsub (
        .a   (as_a),
        .b   (as_b),
        .cin (as_cin),
        .sub (as_sub),
        .sum (as_sum),
        .cout(as_cout),
        .hc  (as_hc),
        .ovf (as_ovf)
    );

    alu8_bitops #(.DW(DW)) u_bitops (
        .op  (op),
        .a   (reg_a),
        .b   (opnd_b),
        .cin (sreg[FLG_C]),
        .tbit(sreg[FLG_T]),
        .bsel(bit_sel),
        .res (bo_res)
    );

    assign result = is_arith ? as_sum : bo_res;

    always_comb begin
        nf = sreg;
        unique case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_NEG: begin
                nf[FLG_C] = as_cout;
                nf[FLG_H] = as_hc;
                nf[FLG_V] = as_ovf;
            end
            OP_INC, OP_DEC: nf[FLG_V] = as_ovf;
            OP_AND, OP_OR, OP_EOR: nf[FLG_V] = 1'b0;
            OP_COM: begin
                nf[FLG_V] = 1'b0;
                nf[FLG_C] = 1'b1;
            end
            OP_LSR, OP_ROR, OP_ASR: begin
                nf[FLG_C] = reg_a[0];
                nf[FLG_V] = result[DW-1] ^ reg_a[0];
            end
            OP_BST: nf[FLG_T] = reg_a[bit_sel];
            OP_BLD: ;
            default: ;
        endcase
        if (op != OP_BST && op != OP_BLD) begin
            nf[FLG_N] = result[DW-1];
            if (op == OP_SBC)
                nf[FLG_Z] = (result == '0) & sreg[FLG_Z];
            else
                nf[FLG_Z] = (result == '0);
            nf[FLG_S] = nf[FLG_N] ^ nf[FLG_V];
        end
    end

    alu8_status u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd       (op_valid),
        .next_flags(nf),
        .we        (sreg_we),
        .wdata     (sreg_wdata),
        .word      (sreg)
    );

    assign irq_gated = sreg[FLG_I] ? irq_req : '0;

endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk
    import alu8_pkg::*;
#(
    parameter int DW    = 8,
    parameter int IRQ_N = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             op_valid,
    input logic [3:0]       op_code,
    input logic [DW-1:0]    result,
    input logic             sreg_we,
    input logic [SW_W-1:0]  sreg_wdata,
    input logic [SW_W-1:0]  sreg,
    input logic [IRQ_N-1:0] irq_gated
);
    logic flag_op;
    assign flag_op = op_valid && !sreg_we && (op_code <= 4'd13);

    p_write_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
        sreg_we |=> sreg == $past(sreg_wdata));

    p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!sreg_we && !op_valid) |=> $stable(sreg));

    p_sign_rule_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flag_op |=> sreg[FLG_S] == (sreg[FLG_N] ^ sreg[FLG_V]));

    p_zero_rule_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_op && op_code != 4'd3) |=> sreg[FLG_Z] == ($past(result) == '0));

    p_logic_keeps_ch_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !sreg_we && op_code >= 4'd4 && op_code <= 4'd6)
        |=> (sreg[FLG_C] == $past(sreg[FLG_C])) && (sreg[FLG_H] == $past(sreg[FLG_H])));

    p_bld_keeps_word_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !sreg_we && op_code == 4'd15) |=> $stable(sreg));

    p_irq_blocked_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !sreg[FLG_I] |-> irq_gated == '0);

endmodule

bind alu8_core alu8_core_chk #(.DW(DW), .IRQ_N(IRQ_N)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .op_code   (op_code),
    .result    (result),
    .sreg_we   (sreg_we),
    .sreg_wdata(sreg_wdata),
    .sreg      (sreg),
    .irq_gated (irq_gated)
);

// File: tb/test_alu8_core.sv
module test_alu8_core;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic [3:0] op_code = '0;
    logic       use_imm = 1'b0;
    logic [7:0] reg_a = '0, reg_b = '0, imm = '0;
    logic [2:0] bit_sel = '0;
    logic [7:0] result;
    logic       sreg_we = 1'b0;
    logic [7:0] sreg_wdata = '0;
    logic [7:0] sreg;
    logic [3:0] irq_req = '0;
    logic [3:0] irq_gated;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;
    logic [7:0] exp_sw = '0;

    always #5 clk = ~clk;

    alu8_core i_alu8_core (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .use_imm(use_imm), .reg_a(reg_a), .reg_b(reg_b), .imm(imm),
        .bit_sel(bit_sel), .result(result), .sreg_we(sreg_we),
        .sreg_wdata(sreg_wdata), .sreg(sreg), .irq_req(irq_req),
        .irq_gated(irq_gated)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    // returns {result, status}
    function automatic logic [15:0] model(input int op, input int a, input int b,
                                          input int bs, input logic [7:0] s);
        int r, res, c, n, v, z, h, t;
        logic [7:0] so;
        c = s[0]; h = s[5]; v = s[3]; t = s[6];
        res = 0;
        so = s;
        case (op)
            0, 1: begin
                r = a + b + ((op == 1) ? s[0] : 0);
                res = r & 255;
                h = (((a & 15) + (b & 15) + ((op == 1) ? s[0] : 0)) > 15) ? 1 : 0;
                c = (r > 255) ? 1 : 0;
                v = (((a ^ res) & (b ^ res) & 128) != 0) ? 1 : 0;
            end
            2, 3, 8: begin
                int x, y, ci;
                x = (op == 8) ? 0 : a;
                y = (op == 8) ? a : b;
                ci = (op == 3) ? int'(s[0]) : 0;
                r = x - y - ci;
                res = r & 255;
                c = (r < 0) ? 1 : 0;
                h = (((x & 15) - (y & 15) - ci) < 0) ? 1 : 0;
                v = (((x ^ y) & (x ^ res) & 128) != 0) ? 1 : 0;
            end
            4: begin res = a & b; v = 0; end
            5: begin res = a | b; v = 0; end
            6: begin res = a ^ b; v = 0; end
            7: begin res = 255 - a; v = 0; c = 1; end
            9:  begin res = (a + 1) & 255; v = (a == 127) ? 1 : 0; end
            10: begin res = (a + 255) & 255; v = (a == 128) ? 1 : 0; end
            11, 12, 13: begin
                res = a / 2;
                if (op == 12) res = res + 128 * int'(s[0]);
                if (op == 13) res = res + (a & 128);
                c = a & 1;
                v = ((res / 128) ^ c);
            end
            14: begin res = a; t = (a >> bs) & 1; end
            default: res = (t != 0) ? (a | (1 << bs)) : (a & ~(1 << bs) & 255);
        endcase
        if (op < 14) begin
            n = res / 128;
            z = (res == 0) ? 1 : 0;
            if (op == 3) z = z & int'(s[1]);
            so[0] = c[0]; so[1] = z[0]; so[2] = n[0]; so[3] = v[0];
            so[4] = n[0] ^ v[0]; so[5] = h[0];
        end
        so[6] = t[0];
        return {res[7:0], so};
    endfunction

    function automatic string tag_of(input int op);
        case (op)
            0, 1: return "R3";
            2, 3: return "R4";
            4, 5, 6, 7: return "R5";
            8: return "R6";
            9, 10: return "R7";
            11, 12, 13: return "R8";
            default: return "R10";
        endcase
    endfunction

    task automatic do_op(input int op, input int a, input int b, input bit im, input int bs);
        logic [15:0] m;
        @(negedge clk);
        m = model(op, a, b, bs, exp_sw);
        op_valid = 1'b1;
        op_code  = op[3:0];
        reg_a    = a[7:0];
        use_imm  = im;
        imm      = im ? b[7:0] : ~b[7:0];
        reg_b    = im ? ~b[7:0] : b[7:0];
        bit_sel  = bs[2:0];
        #1;
        check($sformatf("%s result R14%s op=%0d a=%02h b=%02h", tag_of(op),
              im ? " R2" : "", op, a, b), result, m[15:8]);
        @(posedge clk);
        #1;
        check($sformatf("%s R9 status op=%0d a=%02h b=%02h", tag_of(op), op, a, b),
              sreg, m[7:0]);
        exp_sw = sreg;  // resync to avoid cascaded reports
    endtask

    task automatic wr_sreg(input logic [7:0] v, input bit with_op);
        @(negedge clk);
        sreg_we = 1'b1;
        sreg_wdata = v;
        op_valid = with_op;
        op_code = 4'd0; reg_a = 8'hFF; reg_b = 8'h01; use_imm = 1'b0;
        @(posedge clk);
        #1;
        check(with_op ? "R12 write over operation" : "R12 direct write", sreg, v);
        exp_sw = v;
        @(negedge clk);
        sreg_we = 1'b0;
        op_valid = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        irq_req = 4'b1011;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset status", sreg, 8'h00);
        check("R13 gate closed at reset", {4'h0, irq_gated}, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;

        // flag-producing operations: full first operand, 16 second operands
        for (int op = 0; op < 14; op++)
            for (int a = 0; a < 256; a++)
                for (int k = 0; k < 16; k++)
                    do_op(op, a, (k * 17) ^ (a & 8'h30), k[0], 0);

        // bit transfer over every index
        for (int a = 0; a < 256; a += 3)
            for (int bs = 0; bs < 8; bs++) begin
                do_op(14, a, 0, 1'b0, bs);
                do_op(15, a ^ 8'h5A, 0, 1'b0, bs);
            end

        // R11: operation without valid keeps status but drives result
        wr_sreg(8'h15, 1'b0);
        @(negedge clk);
        op_valid = 1'b0; op_code = 4'd0; use_imm = 1'b0; reg_a = 8'hFF; reg_b = 8'h01;
        #1;
        check("R11 result without valid", result, 8'h00);
        @(posedge clk);
        #1;
        check("R11 status held", sreg, 8'h15);

        // R12: direct write beats a simultaneous operation
        wr_sreg(8'h42, 1'b1);

        // R13: interrupt gate
        wr_sreg(8'h80, 1'b0);
        #1;
        check("R13 gate open", {4'h0, irq_gated}, {4'h0, irq_req});
        wr_sreg(8'h7F, 1'b0);
        #1;
        check("R13 gate closed", {4'h0, irq_gated}, 8'h00);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule